// File: doc/BRIEF.md
# Count-to-Limit Interval Timer

This block holds a set of interval timer channels (two by default) behind one small register window. Every channel has a counter and a limit. All channels share one external strobe that pulses once per microsecond. Each strobe moves a channel's counter up by one. When the counter would reach the programmed limit, it goes back to 1 instead of 0. At the same moment the channel sets its limit flag, which is also that channel's interrupt line. Because the counter restarts at 1, a channel that must fire every N ticks is programmed with a limit of N+1.

Software reaches the channels through a simple register bus: a select, a write enable, a word address, and write and read data. Each 32-bit register word uses the same layout. The flag is in the top bit, the 21-bit count or limit value sits in bits 30:10, and the bits below always read as zero. Reading a channel's limit word acknowledges its interrupt. Writing the limit word restarts the channel. A limit value of 0 or 1 turns the channel into a free-running counter that never interrupts.

Top module: `cnt_limit_timer`

## Requirements
- R1: After a synchronous reset, every channel has counter value 1, limit value 0 and flag 0. All interrupt lines are low and `bus_rdata` is 0.
- R2: A cycle with `tick_us` high increments each channel's counter by exactly one, unless the counter wraps. In a cycle without a tick, the counter keeps its value. The counter never holds 0.
- R3: With a limit value L of 2 or more, the counter runs 1 through L-1. A tick taken at L-1 reloads the counter to 1 and sets the flag. For example, L=4 gives 1, 2, 3, 1. L=2 keeps the counter at 1 and raises the flag on every tick.
- R4: Every register word is laid out as follows: bit 31 is the channel's flag, bits 30:10 are the 21-bit value, and bits 9:0 read 0. The counter word and the limit word of a channel both show that channel's flag.
- R5: Reading a limit word returns the flag as it was before the read. The flag and the interrupt are low from the next cycle on. Reading a counter word leaves the flag unchanged.
- R6: Writing a limit word loads the limit value from write data bits 30:10. In the same cycle it sets the counter to 1 and clears the flag. Write data bit 31 and bits 9:0 are ignored. A limit write in a cycle with a tick takes precedence over the tick for that channel.
- R7: Writes to a counter word have no effect on the counter, the flag or the limit.
- R8: A limit value of 0 or 1 makes the channel free-running. The counter counts up to 2^21-1 and then wraps to 1, and the flag is never set.
- R9: Word address 0 is channel 0's counter, 1 is channel 0's limit, 2 is channel 1's counter and 3 is channel 1's limit. `irq[0]` is channel 0's flag, wired to the lower priority level. `irq[1]` is channel 1's flag, wired to the higher priority level. An access to one channel never changes another channel.
- R10: If a tick wraps a channel in the same cycle as that channel's limit word is read, the flag stays set.
- R11: `bus_rdata` is loaded at the clock edge that samples a read access. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle strobe per microsecond, shared by all channels |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Word address (see R9) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 2 | Per-channel interrupt, equal to the channel's flag |

## Verification
The wrap rule is tested with three limits, each exposing a different way to get it wrong:
- Limit 4 produces the 1, 2, 3, 1 sequence, which separates a reload to 1 from a reload to 0.
- Limit 6, with the other channel running at the same time, exposes wrong reload points and any coupling between the channels.
- Limit 2 is the divide-by-one edge, where every tick must wrap.

Limits 1 and 0 check that the channel free-runs without ever raising a flag. Same-cycle collisions between a tick and a limit read, and between a tick and a limit write, pin down the set-over-clear and write-over-tick priorities. Repeated counter reads and a counter write show that neither has any side effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int TMR_DATA_W = 32;
    localparam int TMR_CNT_W  = 21;
    localparam int TMR_SHIFT  = 10;
    localparam int TMR_FLAG_B = TMR_DATA_W - 1;

    typedef logic [TMR_CNT_W-1:0]  cnt_t;
    typedef logic [TMR_DATA_W-1:0] word_t;

    localparam cnt_t CNT_ONE = cnt_t'(1);
    localparam cnt_t CNT_MAX = {TMR_CNT_W{1'b1}};

    // which word of a channel an address selects
    typedef enum logic {
        REG_COUNT = 1'b0,
        REG_LIMIT = 1'b1
    } reg_sel_e;

    // per-channel access strobes produced by the bus decoder
    typedef struct packed {
        logic rd_cnt;
        logic rd_lim;
        logic wr_lim;
        cnt_t wval;
    } ch_req_t;

    // architectural state of one channel
    typedef struct packed {
        logic flag;
        cnt_t count;
        cnt_t limit;
    } ch_state_t;

    function automatic word_t pack_word(input logic flag, input cnt_t val);
        word_t w;
        w = '0;
        w[TMR_FLAG_B] = flag;
        w[TMR_SHIFT +: TMR_CNT_W] = val;
        return w;
    endfunction

    function automatic cnt_t unpack_val(input word_t w);
        return w[TMR_SHIFT +: TMR_CNT_W];
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  ch_req_t req,
    output word_t   cnt_word,
    output word_t   lim_word,
    output logic    irq
);

    ch_state_t st_q, st_d;

    logic free_run;
    logic at_end;
    logic at_max;
    logic wrap_set;
    logic [TMR_CNT_W:0] count_inc;

    assign free_run  = (st_q.limit <= CNT_ONE);
    assign count_inc = {1'b0, st_q.count} + 1'b1;
    assign at_end    = !free_run && (count_inc >= {1'b0, st_q.limit});
    assign at_max    = (st_q.count == CNT_MAX);
    assign wrap_set  = tick && at_end;

    always_comb begin
        st_d = st_q;
        if (req.wr_lim) begin
            st_d.limit = req.wval;
            st_d.count = CNT_ONE;
            st_d.flag  = 1'b0;
        end else begin
            if (tick) begin
                if (free_run) begin
                    st_d.count = at_max ? CNT_ONE : count_inc[TMR_CNT_W-1:0];
                end else if (at_end) begin
                    st_d.count = CNT_ONE;
                end else begin
                    st_d.count = count_inc[TMR_CNT_W-1:0];
                end
            end
            // a new wrap event wins over an acknowledge in the same cycle
            st_d.flag = wrap_set | (st_q.flag & ~req.rd_lim);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.flag  <= 1'b0;
            st_q.count <= CNT_ONE;
            st_q.limit <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_word = pack_word(st_q.flag, st_q.count);
    assign lim_word = pack_word(st_q.flag, st_q.limit);
    assign irq      = st_q.flag;

    // R2: the counter never holds zero
    assert_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.count != '0);

    // R2: no tick and no limit write leaves the counter untouched
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !req.wr_lim) |=> $stable(st_q.count));

    // R3: the flag only rises together with a reload to one
    assert_rise_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.flag) |-> (st_q.count == CNT_ONE));

    // R3: with an active limit the counter stays below it
    assert_bound_R3: assert property (@(posedge clk) disable iff (rst)
        !free_run |-> (st_q.count < st_q.limit));

    // R5: an acknowledge without a competing tick clears the flag
    assert_rd_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (req.rd_lim && !tick) |=> !st_q.flag);

    // R6: a limit write restarts the channel with the new limit
    assert_wr_load_R6: assert property (@(posedge clk) disable iff (rst)
        req.wr_lim |=> (st_q.count == CNT_ONE && !st_q.flag
                        && st_q.limit == $past(req.wval)));

    // R8: a free-running channel never carries a flag
    assert_free_no_flag_R8: assert property (@(posedge clk) disable iff (rst)
        free_run |-> !st_q.flag);

    // R8: free-running channel wraps from the maximum to one
    assert_free_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && free_run && at_max && !req.wr_lim) |=> (st_q.count == CNT_ONE));

    // R10: a wrap in the cycle of an acknowledge keeps the flag
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (req.rd_lim && tick && at_end) |=> st_q.flag);

endmodule

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = $clog2(NUM_CH) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  word_t                   bus_wdata,
    input  word_t [NUM_CH-1:0]      cnt_words,
    input  word_t [NUM_CH-1:0]      lim_words,
    output ch_req_t [NUM_CH-1:0]    reqs,
    output word_t                   bus_rdata
);

    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0] ch_idx;
    reg_sel_e         which;
    logic             rd_acc;
    logic             wr_acc;
    word_t            rd_mux;
    word_t            rdata_q;
    logic [3*NUM_CH-1:0] all_strobes;

    assign ch_idx = bus_addr[ADDR_W-1:1];
    assign which  = reg_sel_e'(bus_addr[0]);
    assign rd_acc = bus_sel && !bus_wr;
    assign wr_acc = bus_sel && bus_wr;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit            = (ch_idx == IDX_W'(g));
        assign reqs[g].rd_cnt = rd_acc && hit && (which == REG_COUNT);
        assign reqs[g].rd_lim = rd_acc && hit && (which == REG_LIMIT);
        assign reqs[g].wr_lim = wr_acc && hit && (which == REG_LIMIT);
        assign reqs[g].wval   = unpack_val(bus_wdata);
        assign all_strobes[3*g +: 3] = {reqs[g].rd_cnt, reqs[g].rd_lim, reqs[g].wr_lim};
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_idx == IDX_W'(i)) begin
                rd_mux = (which == REG_LIMIT) ? lim_words[i] : cnt_words[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_acc) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

    // R9: one access strobes at most one register of one channel
    assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(all_strobes));

    // R11: read data holds between reads
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |=> $stable(rdata_q));

endmodule

// File: rtl/cnt_limit_timer.sv
module cnt_limit_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int ADDR_W = $clog2(NUM_CH) + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_us,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [TMR_DATA_W-1:0] bus_wdata,
    output logic [TMR_DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0]     irq
);

    ch_req_t [NUM_CH-1:0] reqs;
    word_t   [NUM_CH-1:0] cnt_words;
    word_t   [NUM_CH-1:0] lim_words;

    tmr_bus_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_words (cnt_words),
        .lim_words (lim_words),
        .reqs      (reqs),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_tmr
        tmr_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_us),
            .req      (reqs[g]),
            .cnt_word (cnt_words[g]),
            .lim_word (lim_words[g]),
            .irq      (irq[g])
        );
    end

endmodule

// File: tb/cnt_limit_timer_tb.sv
module cnt_limit_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_us = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    logic rd_seen = 1'b0;

    always #4 clk = ~clk;

    cnt_limit_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_us   (tick_us),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    localparam logic [1:0] A0_CNT = 2'd0, A0_LIM = 2'd1, A1_CNT = 2'd2, A1_LIM = 2'd3;

    function automatic logic [31:0] w(input logic f, input int v);
        return {f, v[20:0], 10'h000};
    endfunction

    // bench-side record of a read being sampled at this edge
    always @(posedge clk) rd_seen <= bus_sel && !bus_wr && !rst;

    // monitor: compares each returned word with the queued expectation
    always @(negedge clk) begin
        if (rd_seen) begin
            sb_item_t it;
            n_checks++;
            if (sb_q.size() == 0) begin
                n_errors++;
                $display("FAIL scoreboard: read with no expectation, got %h exp none", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s: got %h exp %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag,
                      input logic tk = 1'b0);
        sb_item_t it;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; tick_us = tk;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_sel = 1'b0; tick_us = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic tk = 1'b0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_us = tk;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_us = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_us = 1'b1;
            @(negedge clk); tick_us = 1'b0;
        end
    endtask

    task automatic chk_irq(input logic [1:0] exp, input string tag);
        n_checks++;
        if (irq !== exp) begin
            n_errors++;
            $display("FAIL %s: irq got %b exp %b", tag, irq, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_irq(2'b00, "R1 irq in reset");
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (bus_rdata !== 32'h0) begin
            n_errors++;
            $display("FAIL R1 rdata after reset: got %h exp %h", bus_rdata, 32'h0);
        end
        rd(A0_CNT, w(0, 1), "R1 ch0 counter after reset");
        rd(A0_LIM, w(0, 0), "R1 ch0 limit after reset");
        rd(A1_CNT, w(0, 1), "R1 ch1 counter after reset");
        rd(A1_LIM, w(0, 0), "R1 ch1 limit after reset");
        chk_irq(2'b00, "R1 irq after reset");

        // limit 4 with junk in bit 31 and the low bits
        wr(A0_LIM, 32'h8000_0000 | (32'd4 << 10) | 32'h3FF);
        rd(A0_LIM, w(0, 4), "R6 R4 ch0 limit field only");
        rd(A0_CNT, w(0, 1), "R6 ch0 counter restarted");
        ticks(1);
        rd(A0_CNT, w(0, 2), "R2 ch0 one tick");
        ticks(1);
        rd(A0_CNT, w(0, 3), "R3 ch0 sequence 3");
        ticks(1);
        rd(A0_CNT, w(1, 1), "R3 ch0 wrap to 1 with flag");
        chk_irq(2'b01, "R9 only ch0 interrupt");
        rd(A0_CNT, w(1, 1), "R5 counter read keeps flag");
        chk_irq(2'b01, "R5 irq after counter read");
        rd(A0_LIM, w(1, 4), "R5 limit read shows pre-clear flag");
        chk_irq(2'b00, "R5 irq cleared by limit read");
        rd(A0_CNT, w(0, 1), "R5 flag cleared in counter word");

        // two channels with different limits on the shared tick
        wr(A1_LIM, 32'd6 << 10);
        ticks(5);
        chk_irq(2'b11, "R9 both channels wrapped");
        rd(A1_LIM, w(1, 6), "R9 ch1 limit read");
        chk_irq(2'b01, "R9 ch1 ack leaves ch0 interrupt");
        rd(A0_CNT, w(1, 3), "R9 ch0 unaffected by ch1");
        rd(A1_CNT, w(0, 1), "R3 ch1 wrapped after 5 ticks");

        wr(A0_CNT, 32'h1234_5400);
        rd(A0_CNT, w(1, 3), "R7 counter write ignored");
        rd(A0_CNT, w(1, 3), "R7 counter write ignored again");

        // tick wraps ch0 in the same cycle its limit is read
        rd(A0_LIM, w(1, 4), "R10 limit read during wrap", 1'b1);
        chk_irq(2'b01, "R10 flag kept on collision");
        rd(A0_CNT, w(1, 1), "R10 counter reloaded");
        rd(A0_LIM, w(1, 4), "R5 plain acknowledge");
        chk_irq(2'b00, "R5 ch0 cleared");

        // ch1 at 2; two ticks then a limit write colliding with a tick
        ticks(2);
        wr(A1_LIM, 32'd3 << 10, 1'b1);
        rd(A1_CNT, w(0, 1), "R6 write wins over tick");
        chk_irq(2'b01, "R6 ch0 wrapped on same tick");
        rd(A0_LIM, w(1, 4), "R5 ack ch0");

        // free-running with limit 1, then limit 0
        wr(A0_LIM, 32'd1 << 10);
        ticks(10);
        chk_irq(2'b10, "R8 limit 1 raises no interrupt");
        rd(A0_CNT, w(0, 11), "R8 free-running count");
        rd(A0_LIM, w(0, 1), "R8 limit 1 readback");
        wr(A0_LIM, 32'd0);
        ticks(3);
        rd(A0_CNT, w(0, 4), "R8 limit 0 free-running");
        rd(A1_CNT, w(1, 2), "R3 ch1 limit 3 alternates");
        rd(A1_LIM, w(1, 3), "R5 ack ch1");

        // divide-by-one edge
        wr(A1_LIM, 32'd2 << 10);
        ticks(3);
        rd(A1_CNT, w(1, 1), "R3 limit 2 stays at 1");
        rd(A1_LIM, w(1, 2), "R3 limit 2 ack");
        ticks(1);
        chk_irq(2'b10, "R3 limit 2 flags every tick");
        rd(A0_CNT, w(0, 8), "R8 ch0 still free-running");

        repeat (6) @(negedge clk);
        rd(A0_CNT, w(0, 8), "R2 no tick no change");
        rd(A0_CNT, w(0, 8), "R11 repeated read same data");

        repeat (3) @(negedge clk);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_errors++;
            $display("FAIL scoreboard drain: got %0d pending exp 0", sb_q.size());
        end
        finish_run();
    end

endmodule